// File: doc/BRIEF.md
# Bank and Direct-Page Address Generator

This block turns an addressing-mode code and an instruction operand into a 24-bit effective address for a 16-bit microcontroller core. It keeps two base registers. An 8-bit bank register supplies the top byte of addresses in the absolute family of modes. A 16-bit page register sets the lowest address of a 256-byte window in the direct family of modes.

The decoder raises `req_i` for one cycle with a mode, an operand and the two index values. One clock later the block presents the address and the number of address-formation cycles the access costs, and it pulses `valid_o`. When the page base is not a multiple of 256, direct accesses cost one extra cycle. A window placed near the top of bank 0 carries into bank 1 rather than wrapping.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is asserted and until the first request, the bank register holds 0x00, the page register holds 0x0000, and `addr_o`, `cyc_o`, `err_o` and `valid_o` are all zero.
- R2: The bank register changes only on a clock edge where `bank_ld_i` is 1, taking `bank_din_i`. `page_ld_i` and changes on `bank_din_i` without the strobe leave it unchanged.
- R3: The page register takes `page_din_i` on a clock edge where `page_ld_i` is 1 and holds its value otherwise.
- R4: Mode 4 (absolute) and mode 5 (absolute bit) give the address {bank, operand[15:0]}.
- R5: Mode 6 adds the zero-extended X index and mode 7 the zero-extended Y index to {bank, operand[15:0]}, modulo 2^24, so a carry advances the bank.
- R6: Mode 0 (direct) and mode 1 (direct bit) give page + operand[7:0] as a 17-bit sum, zero-extended to 24 bits. Bit 16 selects bank 1, operand[15:8] is ignored, and the bank register is not used.
- R7: Mode 2 adds the X index and mode 3 the Y index to page + operand[7:0]. The sum is taken modulo 2^17, and address bits 23:17 are zero.
- R8: `cyc_o` is 1 for modes 0 to 3 when the low byte of the page register is 0x00, and 2 when it is not. It is 2 for modes 4 to 7.
- R9: The results of a request appear on the outputs one clock after `req_i`, with `valid_o` high for exactly that cycle. Without a request, `valid_o` is 0 and `addr_o` and `cyc_o` hold their values.
- R10: Mode codes 8 to 15 give `addr_o` = 0, `cyc_o` = 0 and `err_o` = 1. A supported mode gives `err_o` = 0.
- R11: When `single_chip_i` is 1, modes 4 to 7 use bank 0x00 in place of the bank register. Direct modes are unaffected.
- R12: A request issued in the same cycle as a register load uses the register value from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_ld_i | input | 1 | Load strobe of the bank register |
| bank_din_i | input | 8 | New bank value |
| page_ld_i | input | 1 | Load strobe of the page register |
| page_din_i | input | 16 | New page base |
| single_chip_i | input | 1 | Forces bank 0 in absolute modes |
| req_i | input | 1 | Address request strobe |
| mode_i | input | 4 | Addressing-mode code |
| operand_i | input | 16 | Instruction operand (low byte in direct modes) |
| idx_x_i | input | 16 | X index value |
| idx_y_i | input | 16 | Y index value |
| addr_o | output | 24 | Effective address |
| cyc_o | output | 3 | Address-formation cycle count |
| err_o | output | 1 | Unsupported mode code |
| valid_o | output | 1 | Outputs belong to the previous cycle's request |

## Verification
The bench places the page at 0xFF80 and at 0xFF01 with indexing, so that the direct sum passes 0xFFFF. A design that wrapped inside bank 0 would return 0x000020 where 0x010020 is expected. A 17-bit overflow case (page 0xFFFF, offset 0xFF, X 0xFFFF) catches a design that keeps the third carry bit. Absolute-indexed carries check that the bank advances. Aligned and unaligned page bases check the extra cycle, and a page-aligned case catches a design that charged the penalty always or never. A load in the same cycle as a request, and single-chip requests with the bank register set to a nonzero value, show whether the design reads the wrong bank value.

// File: rtl/eag_pkg.sv
package eag_pkg;
  parameter int BANK_W   = 8;
  parameter int PAGE_W   = 16;
  parameter int ADDR_W   = BANK_W + PAGE_W;
  parameter int IDX_W    = PAGE_W;
  parameter int DOFS_W   = 8;
  parameter int CYC_W    = 3;
  parameter int MODE_W   = 4;
  parameter int DIR_CYC  = 1;
  parameter int PAGE_PEN = 1;
  parameter int ABS_CYC  = 2;

  localparam logic [MODE_W-1:0] MD_DIR     = MODE_W'(0);
  localparam logic [MODE_W-1:0] MD_DIR_BIT = MODE_W'(1);
  localparam logic [MODE_W-1:0] MD_DIR_X   = MODE_W'(2);
  localparam logic [MODE_W-1:0] MD_DIR_Y   = MODE_W'(3);
  localparam logic [MODE_W-1:0] MD_ABS     = MODE_W'(4);
  localparam logic [MODE_W-1:0] MD_ABS_BIT = MODE_W'(5);
  localparam logic [MODE_W-1:0] MD_ABS_X   = MODE_W'(6);
  localparam logic [MODE_W-1:0] MD_ABS_Y   = MODE_W'(7);

  function automatic logic mode_is_dir(logic [MODE_W-1:0] m);
    return (m == MD_DIR) || (m == MD_DIR_BIT) || (m == MD_DIR_X) || (m == MD_DIR_Y);
  endfunction

  function automatic logic mode_is_abs(logic [MODE_W-1:0] m);
    return (m == MD_ABS) || (m == MD_ABS_BIT) || (m == MD_ABS_X) || (m == MD_ABS_Y);
  endfunction

  // bit 1 of a supported code marks indexing, bit 0 picks Y over X
  function automatic logic [IDX_W-1:0] pick_index(logic [MODE_W-1:0] m,
                                                  logic [IDX_W-1:0] x,
                                                  logic [IDX_W-1:0] y);
    if (!m[1]) return '0;
    return m[0] ? y : x;
  endfunction

  // page window sum kept to 17 bits; bit 16 lands in bank 1
  function automatic logic [ADDR_W-1:0] dir_addr(logic [PAGE_W-1:0] page,
                                                 logic [DOFS_W-1:0] ofs,
                                                 logic [IDX_W-1:0] idx);
    logic [PAGE_W:0] s;
    s = {1'b0, page} + (PAGE_W+1)'(ofs) + (PAGE_W+1)'(idx);
    return ADDR_W'(s);
  endfunction

  function automatic logic [ADDR_W-1:0] abs_addr(logic [BANK_W-1:0] bank,
                                                 logic [PAGE_W-1:0] op,
                                                 logic [IDX_W-1:0] idx);
    return {bank, op} + ADDR_W'(idx);
  endfunction

  function automatic logic [CYC_W-1:0] dir_cycles(logic aligned);
    return aligned ? CYC_W'(DIR_CYC) : CYC_W'(DIR_CYC + PAGE_PEN);
  endfunction
endpackage

// File: rtl/eag_regs.sv
module eag_regs
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_ld,
  input  logic [BANK_W-1:0] bank_din,
  input  logic              page_ld,
  input  logic [PAGE_W-1:0] page_din,
  output logic [BANK_W-1:0] bank_q,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bank_ld) begin
      bank_q <= bank_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (page_ld) begin
      page_q <= page_din;
    end
  end
endmodule

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [PAGE_W-1:0] operand,
  input  logic [IDX_W-1:0]  idx_x,
  input  logic [IDX_W-1:0]  idx_y,
  input  logic [BANK_W-1:0] bank,
  input  logic [PAGE_W-1:0] page,
  input  logic              single_chip,
  output logic [ADDR_W-1:0] addr,
  output logic [CYC_W-1:0]  cyc,
  output logic              bad_mode,
  output logic              page_aligned
);
  logic              is_dir;
  logic              is_abs;
  logic [IDX_W-1:0]  idx_use;
  logic [BANK_W-1:0] eff_bank;

  always_comb begin
    is_dir       = mode_is_dir(mode);
    is_abs       = mode_is_abs(mode);
    bad_mode     = !(is_dir || is_abs);
    idx_use      = pick_index(mode, idx_x, idx_y);
    eff_bank     = single_chip ? '0 : bank;
    page_aligned = (page[DOFS_W-1:0] == '0);
    addr         = '0;
    cyc          = '0;
    if (is_dir) begin
      addr = dir_addr(page, operand[DOFS_W-1:0], idx_use);
      cyc  = dir_cycles(page_aligned);
    end else if (is_abs) begin
      addr = abs_addr(eff_bank, operand, idx_use);
      cyc  = CYC_W'(ABS_CYC);
    end
  end
endmodule

// File: rtl/eag_outreg.sv
module eag_outreg
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr_n,
  input  logic [CYC_W-1:0]  cyc_n,
  input  logic              err_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CYC_W-1:0]  cyc_q,
  output logic              err_q,
  output logic              valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cyc_q   <= '0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req;
      if (req) begin
        addr_q <= addr_n;
        cyc_q  <= cyc_n;
        err_q  <= err_n;
      end
    end
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_ld_i,
  input  logic [BANK_W-1:0] bank_din_i,
  input  logic              page_ld_i,
  input  logic [PAGE_W-1:0] page_din_i,
  input  logic              single_chip_i,
  input  logic              req_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [PAGE_W-1:0] operand_i,
  input  logic [IDX_W-1:0]  idx_x_i,
  input  logic [IDX_W-1:0]  idx_y_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CYC_W-1:0]  cyc_o,
  output logic              err_o,
  output logic              valid_o
);
  logic [BANK_W-1:0] bank_q;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] addr_n;
  logic [CYC_W-1:0]  cyc_n;
  logic              bad_mode;
  logic              page_aligned;

  eag_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_ld  (bank_ld_i),
    .bank_din (bank_din_i),
    .page_ld  (page_ld_i),
    .page_din (page_din_i),
    .bank_q   (bank_q),
    .page_q   (page_q)
  );

  eag_calc u_calc (
    .mode         (mode_i),
    .operand      (operand_i),
    .idx_x        (idx_x_i),
    .idx_y        (idx_y_i),
    .bank         (bank_q),
    .page         (page_q),
    .single_chip  (single_chip_i),
    .addr         (addr_n),
    .cyc          (cyc_n),
    .bad_mode     (bad_mode),
    .page_aligned (page_aligned)
  );

  eag_outreg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_i),
    .addr_n  (addr_n),
    .cyc_n   (cyc_n),
    .err_n   (bad_mode),
    .addr_q  (addr_o),
    .cyc_q   (cyc_o),
    .err_q   (err_o),
    .valid_q (valid_o)
  );
endmodule

// File: rtl/eag_checker.sv
module eag_checker
  import eag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              single_chip_i,
  input logic              bank_ld_i,
  input logic [BANK_W-1:0] bank_din_i,
  input logic              page_ld_i,
  input logic [PAGE_W-1:0] page_din_i,
  input logic [BANK_W-1:0] bank_q,
  input logic [PAGE_W-1:0] page_q,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CYC_W-1:0]  cyc_o,
  input logic              err_o,
  input logic              valid_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (bank_q == '0 && page_q == '0 && !valid_o && addr_o == '0));

  assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ld_i |=> bank_q == $past(bank_din_i));

  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ld_i |=> $stable(bank_q));

  assert_page_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    page_ld_i |=> page_q == $past(page_din_i));

  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !page_ld_i |=> $stable(page_q));

  assert_dir_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_is_dir(mode_i)) |=> addr_o[ADDR_W-1:PAGE_W+1] == '0);

  assert_dir_cycles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_is_dir(mode_i) && page_q[DOFS_W-1:0] == '0) |=> cyc_o == CYC_W'(DIR_CYC));

  assert_dir_penalty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_is_dir(mode_i) && page_q[DOFS_W-1:0] != '0) |=> cyc_o == CYC_W'(DIR_CYC + PAGE_PEN));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!valid_o && $stable(addr_o) && $stable(cyc_o)));

  assert_bad_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && err_o) |-> (addr_o == '0 && cyc_o == '0));

  assert_single_chip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && single_chip_i && (mode_i == MD_ABS || mode_i == MD_ABS_BIT))
      |=> addr_o[ADDR_W-1:PAGE_W] == '0);
endmodule

bind eff_addr_gen eag_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .mode_i        (mode_i),
  .single_chip_i (single_chip_i),
  .bank_ld_i     (bank_ld_i),
  .bank_din_i    (bank_din_i),
  .page_ld_i     (page_ld_i),
  .page_din_i    (page_din_i),
  .bank_q        (bank_q),
  .page_q        (page_q),
  .addr_o        (addr_o),
  .cyc_o         (cyc_o),
  .err_o         (err_o),
  .valid_o       (valid_o)
);

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_ld = 1'b0;
  logic [7:0]  bank_din = '0;
  logic        page_ld = 1'b0;
  logic [15:0] page_din = '0;
  logic        sc = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] opnd = '0;
  logic [15:0] ix = '0;
  logic [15:0] iy = '0;
  logic [23:0] addr;
  logic [2:0]  cyc;
  logic        err;
  logic        valid;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  eff_addr_gen dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bank_ld_i     (bank_ld),
    .bank_din_i    (bank_din),
    .page_ld_i     (page_ld),
    .page_din_i    (page_din),
    .single_chip_i (sc),
    .req_i         (req),
    .mode_i        (mode),
    .operand_i     (opnd),
    .idx_x_i       (ix),
    .idx_y_i       (iy),
    .addr_o        (addr),
    .cyc_o         (cyc),
    .err_o         (err),
    .valid_o       (valid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic load_bank(logic [7:0] v);
    @(negedge clk); bank_ld = 1'b1; bank_din = v;
    @(negedge clk); bank_ld = 1'b0;
  endtask

  task automatic load_page(logic [15:0] v);
    @(negedge clk); page_ld = 1'b1; page_din = v;
    @(negedge clk); page_ld = 1'b0;
  endtask

  // one request; returns with outputs of that request on the ports
  task automatic issue(logic [3:0] m, logic [15:0] op, logic [15:0] x, logic [15:0] y);
    @(negedge clk); req = 1'b1; mode = m; opnd = op; ix = x; iy = y;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic expect_out(string tag, logic [23:0] a, logic [2:0] c);
    check({tag, " valid"}, 32'(valid), 32'd1);
    check({tag, " addr"}, 32'(addr), 32'(a));
    check({tag, " cyc"}, 32'(cyc), 32'(c));
    check({tag, " err"}, 32'(err), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 addr", 32'(addr), 0);
    check("R1 cyc", 32'(cyc), 0);
    check("R1 err", 32'(err), 0);
    check("R1 valid", 32'(valid), 0);
    issue(4'd4, 16'h0000, 16'h0, 16'h0);
    expect_out("R1 bank", 24'h000000, 3'd2);
    issue(4'd0, 16'h0000, 16'h0, 16'h0);
    expect_out("R1 page", 24'h000000, 3'd1);
  endtask

  task automatic t_absolute;
    load_bank(8'h12);
    issue(4'd4, 16'h3456, 16'h9, 16'h9);
    expect_out("R4 abs", 24'h123456, 3'd2);
    issue(4'd5, 16'hABCD, 16'h9, 16'h9);
    expect_out("R4 abs bit", 24'h12ABCD, 3'd2);
  endtask

  task automatic t_bank_guard;
    load_page(16'h0100);
    @(negedge clk); bank_din = 8'h77;
    @(negedge clk); bank_din = 8'h00;
    issue(4'd4, 16'h3456, 16'h0, 16'h0);
    expect_out("R2 bank kept", 24'h123456, 3'd2);
  endtask

  task automatic t_abs_indexed;
    issue(4'd6, 16'hFFF0, 16'h0020, 16'h0001);
    expect_out("R5 abs X carry", 24'h130010, 3'd2);
    issue(4'd7, 16'h1000, 16'h0300, 16'h0005);
    expect_out("R5 abs Y", 24'h121005, 3'd2);
  endtask

  task automatic t_direct;
    load_page(16'h0000);
    issue(4'd0, 16'hAB34, 16'h0, 16'h0);
    expect_out("R6 dir aligned, R8", 24'h000034, 3'd1);
    load_page(16'h1280);
    issue(4'd0, 16'h0010, 16'h0, 16'h0);
    expect_out("R6 dir unaligned, R8", 24'h001290, 3'd2);
    issue(4'd1, 16'hFF10, 16'h0, 16'h0);
    expect_out("R6 dir bit", 24'h001290, 3'd2);
    load_page(16'hFF80);
    issue(4'd0, 16'h00A0, 16'h0, 16'h0);
    expect_out("R6 bank1 carry", 24'h010020, 3'd2);
  endtask

  task automatic t_dir_indexed;
    load_page(16'hFF01);
    issue(4'd2, 16'h00FF, 16'h0100, 16'h7777);
    expect_out("R7 dir X", 24'h010100, 3'd2);
    load_page(16'h2000);
    issue(4'd3, 16'h0010, 16'h5555, 16'h0003);
    expect_out("R7 dir Y, R8", 24'h002013, 3'd1);
    load_page(16'hFFFF);
    issue(4'd2, 16'h00FF, 16'hFFFF, 16'h0);
    expect_out("R7 17-bit wrap", 24'h0000FD, 3'd2);
  endtask

  task automatic t_timing;
    logic [23:0] held;
    held = addr;
    @(negedge clk);
    check("R9 valid drops", 32'(valid), 0);
    check("R9 addr held", 32'(addr), 32'(held));
    check("R9 cyc held", 32'(cyc), 32'd2);
  endtask

  task automatic t_bad_mode;
    issue(4'd9, 16'h1234, 16'h1, 16'h1);
    check("R10 valid", 32'(valid), 1);
    check("R10 addr", 32'(addr), 0);
    check("R10 cyc", 32'(cyc), 0);
    check("R10 err", 32'(err), 1);
    issue(4'd15, 16'hFFFF, 16'h0, 16'h0);
    check("R10 err top code", 32'(err), 1);
    issue(4'd4, 16'h0001, 16'h0, 16'h0);
    expect_out("R10 err clears", 24'h120001, 3'd2);
  endtask

  task automatic t_single_chip;
    sc = 1'b1;
    issue(4'd4, 16'h4000, 16'h0, 16'h0);
    expect_out("R11 abs", 24'h004000, 3'd2);
    issue(4'd6, 16'hFFFF, 16'h0001, 16'h0);
    expect_out("R11 abs X", 24'h010000, 3'd2);
    load_page(16'h1280);
    issue(4'd0, 16'h0010, 16'h0, 16'h0);
    expect_out("R11 dir unaffected", 24'h001290, 3'd2);
    sc = 1'b0;
  endtask

  task automatic t_concurrent;
    @(negedge clk);
    bank_ld = 1'b1; bank_din = 8'h55;
    page_ld = 1'b1; page_din = 16'h3300;
    req = 1'b1; mode = 4'd4; opnd = 16'h0001;
    @(negedge clk);
    bank_ld = 1'b0; page_ld = 1'b0; req = 1'b0;
    expect_out("R12 old bank", 24'h120001, 3'd2);
    issue(4'd4, 16'h0001, 16'h0, 16'h0);
    expect_out("R12 R2 new bank", 24'h550001, 3'd2);
    issue(4'd0, 16'h0001, 16'h0, 16'h0);
    expect_out("R12 R3 new page", 24'h003301, 3'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_absolute();
    t_bank_guard();
    t_abs_indexed();
    t_timing();
    t_direct();
    t_dir_indexed();
    t_bad_mode();
    t_single_chip();
    t_concurrent();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule